// File: doc/BRIEF.md
# Multi-Queue Shared-Buffer FIFO Engine

This block keeps up to 64 independent word FIFOs inside one shared buffer memory. Each queue is described by a configuration word that places it on a page of the buffer, picks one of four capacities and sets two watermark codes. A push stream writes a word into a chosen queue, and a pop request stream takes the oldest word out of a chosen queue. The popped word comes back on a response stream one cycle later.

For every queue the block keeps a read pointer and a write pointer, and from them it derives the flags empty, nearly empty, nearly full and full. Queues in the lower half also keep a sticky overflow flag. Status is read as packed 32-bit words. The lower-half flags are packed as nibbles and the overflow flags as 2-bit fields. The upper half reports only nearly empty and full, one bit per queue, on two dedicated words.

Both streams use valid/ready. A push is taken on a clock edge where push_valid and push_ready are both high. A pop request is taken on an edge where pop_valid and pop_ready are both high. The response has no ready and cannot be stalled. The block lowers a ready only to resolve a same-cycle collision on one queue, as R11 describes.

Top module: `mqfifo_engine`

## Requirements
- R1: After reset, every lower-half status nibble reads 0x3, every overflow field reads 0, every upper-half nearly-empty bit reads 1 and every upper-half full bit reads 0.
- R2: Configuration word fields are: base page in bits 21:14, size code in bits 25:24, nearly-empty code in bits 28:26 and nearly-full code in bits 31:29. A queue is in use only while its base page is nonzero. A push to a queue that is not in use is discarded without setting overflow. A pop from such a queue returns 0.
- R3: Words pop out of a queue in the order they were pushed. rsp_valid is high for exactly one cycle, in the cycle after each accepted pop request, and never otherwise.
- R4: Size codes 0, 1, 2 and 3 give capacities of 16, 32, 64 and 128 words. The queue is stored from word base_page*16 of the buffer.
- R5: A push to a full queue is discarded. For queue q < 32 it sets a sticky overflow flag at bit 2*(q mod 16) of stat2 word q/16; bit 2*(q mod 16)+1 always reads 0. The flag clears when ovf_clr_we is high with mask bit q set. A set in the same cycle wins over the clear.
- R6: A pop from an empty queue returns 0 and leaves the queue's contents and pointers unchanged.
- R7: Nearly empty is 1 when the fill level is at most the nearly-empty threshold. Code 0 gives threshold 0, and code k>0 gives 2^(k-1).
- R8: Nearly full is 1 when the free space (capacity minus level) is at most the threshold decoded from the nearly-full code, using the same decode as R7.
- R9: For queue q < 32 the nibble sits at bits 4*(q mod 8)+3 : 4*(q mod 8) of stat1 word q/8. Bit 0 is empty, bit 1 is nearly empty, bit 2 is nearly full and bit 3 is full.
- R10: For queue q >= 32, nearly empty appears on ne_hi bit q-32 and full appears on full_hi bit q-32.
- R11: push_ready is 0 while pop_valid, or cfg_we, targets the same queue as push_qid. pop_ready is 0 while cfg_we targets the same queue as pop_qid. Otherwise both are 1.
- R12: A configuration write empties the queue it targets and clears that queue's overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | 6 | Queue being configured |
| cfg_wdata | input | 32 | Configuration word |
| push_valid | input | 1 | Push stream valid |
| push_ready | output | 1 | Push stream ready |
| push_qid | input | 6 | Target queue of the push |
| push_data | input | 32 | Word to push |
| pop_valid | input | 1 | Pop request valid |
| pop_ready | output | 1 | Pop request ready |
| pop_qid | input | 6 | Queue to pop |
| rsp_valid | output | 1 | Popped word valid |
| rsp_data | output | 32 | Popped word (0 on empty or unused queue) |
| ovf_clr_we | input | 1 | Overflow clear strobe |
| ovf_clr_mask | input | 32 | Write-one-to-clear mask, one bit per lower queue |
| stat1_sel | input | 2 | Selects the nibble status word |
| stat1_word | output | 32 | Packed 4-flag status of 8 lower queues |
| stat2_sel | input | 1 | Selects the overflow status word |
| stat2_word | output | 32 | Packed 2-bit overflow fields of 16 lower queues |
| ne_hi | output | 32 | Nearly-empty bits of the upper queues |
| full_hi | output | 32 | Full bits of the upper queues |

## Verification
A push or a configuration write updates the pointers on the clock edge that accepts it. The status words are decoded combinationally from those registers, so the new flags are visible right after that edge. A popped word is registered, so rsp_valid and rsp_data appear one edge after the accepted request. The bench drives inputs and samples outputs on falling edges. It reads status half a cycle after the accepting edge. A monitor compares each response, at the falling edge after the accepting edge, against a scoreboard queue that the pop driver fills from a per-queue reference model.

// File: rtl/mqfifo_pkg.sv
package mqfifo_pkg;

  typedef struct packed {
    logic [2:0] nf_code;
    logic [2:0] ne_code;
    logic [1:0] size_code;
    logic [7:0] base;
  } qcfg_t;

  typedef struct packed {
    logic full;
    logic nfull;
    logic nempty;
    logic empty;
  } qflags_t;

  function automatic qcfg_t cfg_unpack(logic [31:0] w);
    qcfg_t c;
    c.base      = w[21:14];
    c.size_code = w[25:24];
    c.ne_code   = w[28:26];
    c.nf_code   = w[31:29];
    return c;
  endfunction

  function automatic logic [7:0] size_words(logic [1:0] code);
    return 8'd16 << code;
  endfunction

  function automatic logic [7:0] wm_thresh(logic [2:0] code);
    return (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
  endfunction

endpackage

// File: rtl/mqfifo_ptr_bank.sv
module mqfifo_ptr_bank #(
  parameter int NQ = 64,
  parameter int QW = 6,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [QW-1:0] push_q,
  input  logic          pop_en,
  input  logic [QW-1:0] pop_q,
  input  logic          clr_en,
  input  logic [QW-1:0] clr_q,
  output logic [PW-1:0] rd_ptr [NQ],
  output logic [PW-1:0] wr_ptr [NQ]
);
  for (genvar i = 0; i < NQ; i++) begin : g_q
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_ptr[i] <= '0;
        wr_ptr[i] <= '0;
      end else if (clr_en && clr_q == QW'(i)) begin
        rd_ptr[i] <= '0;
        wr_ptr[i] <= '0;
      end else begin
        if (push_en && push_q == QW'(i)) wr_ptr[i] <= wr_ptr[i] + 1'b1;
        if (pop_en && pop_q == QW'(i))   rd_ptr[i] <= rd_ptr[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mqfifo_flag_gen.sv
module mqfifo_flag_gen
  import mqfifo_pkg::*;
#(
  parameter int NQ = 64,
  parameter int PW = 8
) (
  input  qcfg_t         cfg   [NQ],
  input  logic [PW-1:0] rd_ptr [NQ],
  input  logic [PW-1:0] wr_ptr [NQ],
  output qflags_t       flags [NQ]
);
  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic [7:0] level, cap, room;
    always_comb begin
      level = 8'(wr_ptr[i] - rd_ptr[i]);
      cap   = size_words(cfg[i].size_code);
      room  = cap - level;
      flags[i].empty  = (level == 8'd0);
      flags[i].nempty = (level <= wm_thresh(cfg[i].ne_code));
      flags[i].nfull  = (room <= wm_thresh(cfg[i].nf_code));
      flags[i].full   = (level == cap);
    end
  end
endmodule

// File: rtl/mqfifo_buffer.sv
module mqfifo_buffer #(
  parameter int DW    = 32,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic          rd_zero,
  input  logic [AW-1:0] raddr,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= re;
      if (re) rdata <= rd_zero ? '0 : mem[raddr];
    end
  end
endmodule

// File: rtl/mqfifo_engine.sv
module mqfifo_engine
  import mqfifo_pkg::*;
#(
  parameter int NUM_Q     = 64,
  parameter int DW        = 32,
  parameter int MEM_WORDS = 2048,
  localparam int QW   = $clog2(NUM_Q),
  localparam int HALF = NUM_Q / 2,
  localparam int S1N  = HALF / 8,
  localparam int S2N  = HALF / 16,
  localparam int S1W  = (S1N > 1) ? $clog2(S1N) : 1,
  localparam int S2W  = (S2N > 1) ? $clog2(S2N) : 1,
  localparam int AW   = $clog2(MEM_WORDS),
  localparam int PW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [QW-1:0]   cfg_qid,
  input  logic [31:0]     cfg_wdata,
  input  logic            push_valid,
  output logic            push_ready,
  input  logic [QW-1:0]   push_qid,
  input  logic [DW-1:0]   push_data,
  input  logic            pop_valid,
  output logic            pop_ready,
  input  logic [QW-1:0]   pop_qid,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  input  logic            ovf_clr_we,
  input  logic [HALF-1:0] ovf_clr_mask,
  input  logic [S1W-1:0]  stat1_sel,
  output logic [31:0]     stat1_word,
  input  logic [S2W-1:0]  stat2_sel,
  output logic [31:0]     stat2_word,
  output logic [HALF-1:0] ne_hi,
  output logic [HALF-1:0] full_hi
);
  qcfg_t         cfg_r  [NUM_Q];
  logic [PW-1:0] rd_ptr [NUM_Q];
  logic [PW-1:0] wr_ptr [NUM_Q];
  qflags_t       flags  [NUM_Q];
  logic [HALF-1:0] ovf_r;

  // stream handshakes and collision rules
  assign push_ready = !(pop_valid && pop_qid == push_qid) && !(cfg_we && cfg_qid == push_qid);
  assign pop_ready  = !(cfg_we && cfg_qid == pop_qid);

  logic push_fire, pop_fire, push_inuse, pop_inuse, push_ok, pop_ok, push_drop;
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_valid && pop_ready;
  assign push_inuse = cfg_r[push_qid].base != 8'd0;
  assign pop_inuse  = cfg_r[pop_qid].base != 8'd0;
  assign push_ok    = push_fire && push_inuse && !flags[push_qid].full;
  assign push_drop  = push_fire && push_inuse && flags[push_qid].full;
  assign pop_ok     = pop_fire && pop_inuse && !flags[pop_qid].empty;

  // buffer addressing: page*16 plus offset wrapped to the queue capacity
  logic [6:0]  wmask, rmask;
  logic [11:0] waddr_full, raddr_full;
  always_comb begin
    wmask      = 7'(size_words(cfg_r[push_qid].size_code) - 8'd1);
    rmask      = 7'(size_words(cfg_r[pop_qid].size_code) - 8'd1);
    waddr_full = {cfg_r[push_qid].base, 4'b0} + {5'b0, wr_ptr[push_qid][6:0] & wmask};
    raddr_full = {cfg_r[pop_qid].base, 4'b0}  + {5'b0, rd_ptr[pop_qid][6:0] & rmask};
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) cfg_r[i] <= '0;
    end else if (cfg_we) begin
      cfg_r[cfg_qid] <= cfg_unpack(cfg_wdata);
    end
  end

  // sticky overflow, lower half only; a set beats a clear
  for (genvar i = 0; i < HALF; i++) begin : g_ovf
    always_ff @(posedge clk) begin
      if (!rst_n) ovf_r[i] <= 1'b0;
      else if (push_drop && push_qid == QW'(i)) ovf_r[i] <= 1'b1;
      else if (cfg_we && cfg_qid == QW'(i)) ovf_r[i] <= 1'b0;
      else if (ovf_clr_we && ovf_clr_mask[i]) ovf_r[i] <= 1'b0;
    end
  end

  mqfifo_ptr_bank #(.NQ(NUM_Q), .QW(QW), .PW(PW)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_en(push_ok),
    .push_q (push_qid),
    .pop_en (pop_ok),
    .pop_q  (pop_qid),
    .clr_en (cfg_we),
    .clr_q  (cfg_qid),
    .rd_ptr (rd_ptr),
    .wr_ptr (wr_ptr)
  );

  mqfifo_flag_gen #(.NQ(NUM_Q), .PW(PW)) u_flags (
    .cfg   (cfg_r),
    .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr),
    .flags (flags)
  );

  mqfifo_buffer #(.DW(DW), .DEPTH(MEM_WORDS)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (push_ok),
    .waddr  (waddr_full[AW-1:0]),
    .wdata  (push_data),
    .re     (pop_fire),
    .rd_zero(!pop_ok),
    .raddr  (raddr_full[AW-1:0]),
    .rvalid (rsp_valid),
    .rdata  (rsp_data)
  );

  // packed status views
  always_comb begin
    stat1_word = '0;
    stat2_word = '0;
    for (int i = 0; i < 8; i++)
      stat1_word[4*i +: 4] = flags[int'(stat1_sel) * 8 + i];
    for (int i = 0; i < 16; i++)
      stat2_word[2*i] = ovf_r[int'(stat2_sel) * 16 + i];
  end

  for (genvar i = 0; i < HALF; i++) begin : g_hi
    assign ne_hi[i]   = flags[HALF + i].nempty;
    assign full_hi[i] = flags[HALF + i].full;
  end
endmodule

// File: rtl/mqfifo_engine_chk.sv
module mqfifo_engine_chk #(
  parameter int QW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          push_ready,
  input logic [QW-1:0] push_qid,
  input logic          pop_valid,
  input logic          pop_ready,
  input logic [QW-1:0] pop_qid,
  input logic          cfg_we,
  input logic [QW-1:0] cfg_qid,
  input logic          rsp_valid,
  input logic [31:0]   stat1_word
);
  assert_rsp_after_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready) |=> rsp_valid);

  assert_no_stray_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_valid && pop_ready) |=> !rsp_valid);

  assert_push_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && ((pop_valid && pop_qid == push_qid) || (cfg_we && cfg_qid == push_qid)))
      |-> !push_ready);

  assert_pop_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && cfg_we && cfg_qid == pop_qid) |-> !pop_ready);

  for (genvar i = 0; i < 8; i++) begin : g_nib
    assert_empty_implies_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat1_word[4*i] |-> stat1_word[4*i+1]);
    assert_full_implies_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat1_word[4*i+3] |-> stat1_word[4*i+2]);
  end
endmodule

bind mqfifo_engine mqfifo_engine_chk #(.QW(QW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_valid(push_valid),
  .push_ready(push_ready),
  .push_qid  (push_qid),
  .pop_valid (pop_valid),
  .pop_ready (pop_ready),
  .pop_qid   (pop_qid),
  .cfg_we    (cfg_we),
  .cfg_qid   (cfg_qid),
  .rsp_valid (rsp_valid),
  .stat1_word(stat1_word)
);

// File: tb/mqfifo_engine_test.sv
module mqfifo_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 0, push_valid = 0, pop_valid = 0, ovf_clr_we = 0;
  logic [5:0]  cfg_qid = 0, push_qid = 0, pop_qid = 0;
  logic [31:0] cfg_wdata = 0, push_data = 0, ovf_clr_mask = 0;
  logic [1:0]  stat1_sel = 0;
  logic        stat2_sel = 0;
  logic        push_ready, pop_ready, rsp_valid;
  logic [31:0] rsp_data, stat1_word, stat2_word, ne_hi, full_hi;

  mqfifo_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid), .cfg_wdata(cfg_wdata),
    .push_valid(push_valid), .push_ready(push_ready), .push_qid(push_qid), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_qid(pop_qid),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ovf_clr_we(ovf_clr_we), .ovf_clr_mask(ovf_clr_mask),
    .stat1_sel(stat1_sel), .stat1_word(stat1_word),
    .stat2_sel(stat2_sel), .stat2_word(stat2_word),
    .ne_hi(ne_hi), .full_hi(full_hi)
  );

  int n_tests = 0, n_fail = 0;
  logic [31:0] mdl [64][$];
  int cap [64];
  int nec [64];
  int nfc [64];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: responses due one edge after the accepted request
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check_eq("R3", 32'd1, 32'd0);
      else check_eq(tag_q.pop_front(), rsp_data, exp_q.pop_front());
    end
  end

  function automatic int thr(int c);
    return (c == 0) ? 0 : (1 << (c - 1));
  endfunction

  function automatic logic [3:0] exp_nib(int q);
    int lvl, room;
    if (cap[q] == 0) return 4'h3;
    lvl  = mdl[q].size();
    room = cap[q] - lvl;
    return {lvl == cap[q], room <= thr(nfc[q]), lvl <= thr(nec[q]), lvl == 0};
  endfunction

  task automatic do_cfg(int q, int base, int sz, int ne, int nf);
    @(negedge clk);
    cfg_we = 1; cfg_qid = 6'(q);
    cfg_wdata = (32'(nf) << 29) | (32'(ne) << 26) | (32'(sz) << 24) | (32'(base) << 14);
    @(posedge clk); #1 cfg_we = 0;
    mdl[q].delete();
    cap[q] = (base != 0) ? (16 << sz) : 0;
    nec[q] = ne; nfc[q] = nf;
  endtask

  task automatic do_push(int q, logic [31:0] d);
    @(negedge clk);
    push_valid = 1; push_qid = 6'(q); push_data = d;
    @(posedge clk); #1 push_valid = 0;
    if (mdl[q].size() < cap[q]) mdl[q].push_back(d);
  endtask

  task automatic do_pop(int q, string req);
    @(negedge clk);
    pop_valid = 1; pop_qid = 6'(q);
    if (mdl[q].size() > 0) exp_q.push_back(mdl[q].pop_front());
    else exp_q.push_back(32'd0);
    tag_q.push_back(req);
    @(posedge clk); #1 pop_valid = 0;
  endtask

  task automatic chk_nib(int q, string req);
    @(negedge clk);
    stat1_sel = 2'(q / 8);
    #1 check_eq(req, 32'(stat1_word[(q % 8) * 4 +: 4]), 32'(exp_nib(q)));
  endtask

  task automatic chk_ovf(int q, logic e, string req);
    @(negedge clk);
    stat2_sel = 1'(q / 16);
    #1 check_eq(req, 32'(stat2_word[2 * (q % 16) +: 2]), {31'd0, e});
  endtask

  task automatic chk_hi(int q, string req);
    @(negedge clk);
    #1;
    check_eq(req, 32'(ne_hi[q - 32]), 32'(exp_nib(q) >> 1 & 4'h1));
    check_eq(req, 32'(full_hi[q - 32]), 32'(exp_nib(q) >> 3 & 4'h1));
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin cap[i] = 0; nec[i] = 0; nfc[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); stat1_sel = 2'(s);
      #1 check_eq("R1 stat1", stat1_word, 32'h33333333);
    end
    for (int s = 0; s < 2; s++) begin
      @(negedge clk); stat2_sel = 1'(s);
      #1 check_eq("R1 stat2", stat2_word, 32'h0);
    end
    check_eq("R1 ne_hi", ne_hi, 32'hFFFFFFFF);
    check_eq("R1 full_hi", full_hi, 32'h0);

    // R4 R7 R8 R9: queue 3, 16 words, ne thr 2, nf thr 1
    do_cfg(3, 4, 0, 2, 1);
    chk_nib(3, "R9 cfg");
    do_push(3, 32'hA000_0000); chk_nib(3, "R7 level1");
    do_push(3, 32'hA000_0001); do_push(3, 32'hA000_0002); chk_nib(3, "R7 level3");
    for (int i = 3; i < 15; i++) do_push(3, 32'hA000_0000 + 32'(i));
    chk_nib(3, "R8 level15");
    do_push(3, 32'hA000_000F); chk_nib(3, "R4 full16");
    check_eq("R4 full16 nibble", 32'(exp_nib(3)), 32'hC);
    // R5 overflow
    do_push(3, 32'hDEAD_BEEF);
    chk_ovf(3, 1'b1, "R5 set");
    chk_nib(3, "R5 still full");
    @(negedge clk); ovf_clr_we = 1; ovf_clr_mask = 32'h1 << 3;
    @(posedge clk); #1 ovf_clr_we = 0;
    chk_ovf(3, 1'b0, "R5 clear");
    // R3 order
    for (int i = 0; i < 16; i++) do_pop(3, "R3 order");
    chk_nib(3, "R9 drained");
    // R6 empty pop
    do_pop(3, "R6 empty pop");
    chk_nib(3, "R6 unchanged");
    do_push(3, 32'h1234_5678); do_pop(3, "R6 after empty");

    // R7 R8 with code 3 (thr 4) on queue 6
    do_cfg(6, 32, 0, 3, 3);
    for (int i = 0; i < 4; i++) do_push(6, 32'h6000 + 32'(i));
    chk_nib(6, "R7 at thr");
    do_push(6, 32'h6004); chk_nib(6, "R7 above thr");
    for (int i = 5; i < 11; i++) do_push(6, 32'h6000 + 32'(i));
    chk_nib(6, "R8 free5");
    do_push(6, 32'h600B); chk_nib(6, "R8 free4");

    // R10 R4: upper queue 40, 32 words
    do_cfg(40, 8, 1, 0, 0);
    chk_hi(40, "R10 empty");
    do_push(40, 32'h4000_0000); chk_hi(40, "R10 one");
    for (int i = 1; i < 32; i++) do_push(40, 32'h4000_0000 + 32'(i));
    chk_hi(40, "R10 full32");
    do_push(40, 32'hBAD0_BAD0);
    for (int i = 0; i < 32; i++) do_pop(40, "R4 cap32 order");
    chk_hi(40, "R10 drained");

    // R4 cap64 on queue 1
    do_cfg(1, 24, 2, 0, 0);
    for (int i = 0; i < 63; i++) do_push(1, 32'h1000 + 32'(i));
    chk_nib(1, "R4 cap64 minus1");
    do_push(1, 32'h10FF); chk_nib(1, "R4 cap64 full");
    for (int i = 0; i < 3; i++) do_pop(1, "R3 cap64");

    // R4 R12 cap128 on queue 20
    do_cfg(20, 16, 3, 0, 0);
    for (int i = 0; i < 128; i++) do_push(20, 32'h2000 + 32'(i));
    chk_nib(20, "R4 cap128 full");
    do_push(20, 32'hFFFF_0000);
    chk_ovf(20, 1'b1, "R5 q20");
    do_cfg(20, 16, 3, 0, 0);
    chk_nib(20, "R12 emptied");
    chk_ovf(20, 1'b0, "R12 ovf cleared");
    do_pop(20, "R12 pop after cfg");

    // R2 unused queue 5
    do_push(5, 32'h5555_5555);
    chk_nib(5, "R2 unused status");
    chk_ovf(5, 1'b0, "R2 no overflow");
    do_pop(5, "R2 unused pop");

    // R11 collisions
    do_push(3, 32'hC011_0001);
    @(negedge clk);
    push_valid = 1; push_qid = 6'd3; push_data = 32'hC011_0002;
    pop_valid = 1; pop_qid = 6'd3;
    #1 check_eq("R11 push held", 32'(push_ready), 32'd0);
    check_eq("R11 pop free", 32'(pop_ready), 32'd1);
    exp_q.push_back(mdl[3].pop_front()); tag_q.push_back("R11 pop");
    @(posedge clk); #1 pop_valid = 0;
    @(negedge clk);
    #1 check_eq("R11 push released", 32'(push_ready), 32'd1);
    @(posedge clk); #1 push_valid = 0;
    mdl[3].push_back(32'hC011_0002);
    do_pop(3, "R11 held word");
    @(negedge clk);
    cfg_we = 1; cfg_qid = 6'd6; cfg_wdata = 32'(32) << 14;
    pop_valid = 1; pop_qid = 6'd6;
    #1 check_eq("R11 pop held", 32'(pop_ready), 32'd0);
    @(posedge clk); #1 cfg_we = 0; pop_valid = 0;
    mdl[6].delete(); nec[6] = 0; nfc[6] = 0;

    repeat (4) @(negedge clk);
    check_eq("R3 all responses", 32'(exp_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule